// File: doc/BRIEF.md
# Host and DMA Shared-RAM Arbiter

This block decides, cycle by cycle, who drives a single-port internal RAM: a host subsystem making read/write accesses, or a DMA burst engine that copies a fully validated message into that RAM. Most of the time the host owns the RAM outright and each request reaches the RAM in the same cycle. A completion-strobe window from the receive path announces that a burst is coming. The burst itself starts when that window closes.

When the window opens, a host access that is already underway is allowed to finish. The host gets a short active-low acknowledge pulse, and the access must end by a fixed deadline inside the window. If it has not ended by then, it is cut off and a sticky timeout flag is raised. A host access that starts after the window has opened gets no acknowledge. It is held off through the rest of the window and the whole DMA burst. The hold drops in the cycle after the DMA engine signals that it is done, and the waiting request is served in that same cycle. All durations are parameters counted in clock cycles.

Top module: `ram_share_arbiter`

## Requirements
- R1: Outside a window and a DMA phase, the RAM copies the host request in the same cycle. `ram_en` equals `host_req`, and write enable, address and data follow the host. `host_hold` is low and `host_ack_n` is high.
- R2: The window starts in the first cycle in which `strobe_win` is seen high while idle. If `host_req` is high in that cycle, the access counts as in progress. `host_ack_n` is then low for exactly ACK_CYC cycles, starting in the next cycle. The host keeps the RAM for as long as it holds `host_req`.
- R3: A host request that was not in progress when the window started gets no acknowledge. In every cycle of the window and of the DMA phase it sees `host_hold` high and `ram_en` low on its behalf.
- R4: An in-progress access is granted only in window cycles 0 through ACK_CYC+FINISH_CYC-1, counted from the cycle after the start. It is aborted if it is still requesting at cycle ACK_CYC+FINISH_CYC, or in the cycle the window input falls. On an abort, `ram_en` is low in that cycle and `host_timeout` is high from the next cycle. Only reset clears `host_timeout`.
- R5: The DMA phase starts in the cycle after `strobe_win` is seen low in the window. In that phase the RAM follows the `dma_*` inputs whenever `dma_req` is high. At all other times `dma_req` has no effect on the RAM.
- R6: A `dma_done` pulse in the DMA phase ends it. `host_hold` is low from the next cycle, and a host request pending in that cycle reaches the RAM at once.
- R7: Synchronous active-high reset gives `host_hold` low, `host_ack_n` high and `host_timeout` low, with the host owning the RAM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Host access request, held for the length of the access |
| host_we | input | 1 | Host write enable |
| host_addr | input | ADDR_W | Host address |
| host_wdata | input | DATA_W | Host write data |
| strobe_win | input | 1 | Completion-strobe window from the receive path, active high |
| dma_req | input | 1 | DMA engine RAM access request |
| dma_we | input | 1 | DMA write enable |
| dma_addr | input | ADDR_W | DMA address |
| dma_wdata | input | DATA_W | DMA write data |
| dma_done | input | 1 | One-cycle pulse: DMA burst complete |
| host_ack_n | output | 1 | Active-low acknowledge for an access in progress at window start |
| host_hold | output | 1 | Host is currently held off the RAM |
| host_timeout | output | 1 | Sticky flag: an in-progress access was aborted |
| ram_en | output | 1 | RAM access enable |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | ADDR_W | RAM address |
| ram_wdata | output | DATA_W | RAM write data |

## Verification
One cycle-by-cycle vector walk covers the full sequence: free host traffic with a stray DMA request, a window that opens over a live host access, that access finishing early, a late request, the DMA burst and the release. The walk distinguishes the in-progress case from the late-request case by the acknowledge and the grant. Directed runs then hold a request past the deadline and close a window over a live access, which tells the deadline abort apart from the window-end abort. A further directed run opens a window with no host activity, to show that no acknowledge is given. A last run leaves a request pending across `dma_done`, which pins the release to the exact cycle.

// File: rtl/ram_arb_pkg.sv
package ram_arb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WIN  = 2'd1,
        ST_DMA  = 2'd2
    } arb_state_e;

    typedef enum logic [1:0] {
        OWN_NONE = 2'd0,
        OWN_HOST = 2'd1,
        OWN_DMA  = 2'd2
    } ram_owner_e;

    // Last window cycle index (exclusive) in which an in-flight access may run
    function automatic int win_limit(input int ack_cyc, input int finish_cyc);
        return ack_cyc + finish_cyc;
    endfunction

    function automatic int cnt_width(input int limit);
        return (limit < 2) ? 1 : $clog2(limit + 1);
    endfunction

endpackage

// File: rtl/arb_ctrl.sv
module arb_ctrl
    import ram_arb_pkg::*;
#(
    parameter int ACK_CYC    = 10,
    parameter int FINISH_CYC = 160
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       strobe_win,
    input  logic       host_req,
    input  logic       dma_req,
    input  logic       dma_done,
    output ram_owner_e owner,
    output logic       host_ack_n,
    output logic       host_hold,
    output logic       host_timeout
);
    localparam int LIMIT = win_limit(ACK_CYC, FINISH_CYC);
    localparam int CNT_W = cnt_width(LIMIT);
    localparam logic [CNT_W-1:0] LIMIT_V = CNT_W'(LIMIT);
    localparam logic [CNT_W-1:0] ACK_V   = CNT_W'(ACK_CYC);

    arb_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             infl_q, infl_d;
    logic             ackd_q, ackd_d;
    logic             tout_q, tout_d;
    logic             in_time;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        infl_d  = infl_q;
        ackd_d  = ackd_q;
        tout_d  = tout_q;
        owner   = OWN_NONE;
        in_time = strobe_win && (cnt_q < LIMIT_V);
        case (state_q)
            ST_IDLE: begin
                if (host_req) owner = OWN_HOST;
                if (strobe_win) begin
                    state_d = ST_WIN;
                    cnt_d   = '0;
                    infl_d  = host_req;
                    ackd_d  = host_req;
                end
            end
            ST_WIN: begin
                if (infl_q && host_req) begin
                    if (in_time) begin
                        owner = OWN_HOST;
                    end else begin
                        tout_d = 1'b1;
                        infl_d = 1'b0;
                    end
                end
                if (!host_req) infl_d = 1'b0;
                if (cnt_q != LIMIT_V) cnt_d = cnt_q + 1'b1;
                if (!strobe_win) begin
                    state_d = ST_DMA;
                    infl_d  = 1'b0;
                end
            end
            ST_DMA: begin
                if (dma_req) owner = OWN_DMA;
                if (dma_done) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            infl_q  <= 1'b0;
            ackd_q  <= 1'b0;
            tout_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            infl_q  <= infl_d;
            ackd_q  <= ackd_d;
            tout_q  <= tout_d;
        end
    end

    assign host_ack_n   = !((state_q == ST_WIN) && ackd_q && (cnt_q < ACK_V));
    assign host_hold    = (state_q != ST_IDLE) && (owner != OWN_HOST);
    assign host_timeout = tout_q;

endmodule

// File: rtl/ram_port_mux.sv
module ram_port_mux
    import ram_arb_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 16
) (
    input  ram_owner_e        owner,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              dma_we,
    input  logic [ADDR_W-1:0] dma_addr,
    input  logic [DATA_W-1:0] dma_wdata,
    output logic              ram_en,
    output logic              ram_we,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [DATA_W-1:0] ram_wdata
);
    always_comb begin
        ram_en    = 1'b0;
        ram_we    = 1'b0;
        ram_addr  = '0;
        ram_wdata = '0;
        case (owner)
            OWN_HOST: begin
                ram_en    = 1'b1;
                ram_we    = host_we;
                ram_addr  = host_addr;
                ram_wdata = host_wdata;
            end
            OWN_DMA: begin
                ram_en    = 1'b1;
                ram_we    = dma_we;
                ram_addr  = dma_addr;
                ram_wdata = dma_wdata;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/ram_share_arbiter.sv
module ram_share_arbiter
    import ram_arb_pkg::*;
#(
    parameter int ADDR_W     = 10,
    parameter int DATA_W     = 16,
    parameter int ACK_CYC    = 10,
    parameter int FINISH_CYC = 160
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_req,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              strobe_win,
    input  logic              dma_req,
    input  logic              dma_we,
    input  logic [ADDR_W-1:0] dma_addr,
    input  logic [DATA_W-1:0] dma_wdata,
    input  logic              dma_done,
    output logic              host_ack_n,
    output logic              host_hold,
    output logic              host_timeout,
    output logic              ram_en,
    output logic              ram_we,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [DATA_W-1:0] ram_wdata
);
    ram_owner_e owner;

    arb_ctrl #(
        .ACK_CYC    (ACK_CYC),
        .FINISH_CYC (FINISH_CYC)
    ) u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .strobe_win   (strobe_win),
        .host_req     (host_req),
        .dma_req      (dma_req),
        .dma_done     (dma_done),
        .owner        (owner),
        .host_ack_n   (host_ack_n),
        .host_hold    (host_hold),
        .host_timeout (host_timeout)
    );

    ram_port_mux #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_mux (
        .owner      (owner),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .dma_we     (dma_we),
        .dma_addr   (dma_addr),
        .dma_wdata  (dma_wdata),
        .ram_en     (ram_en),
        .ram_we     (ram_we),
        .ram_addr   (ram_addr),
        .ram_wdata  (ram_wdata)
    );
endmodule

// File: rtl/ram_share_arbiter_chk.sv
module ram_share_arbiter_chk (
    input logic clk,
    input logic rst,
    input logic host_req,
    input logic strobe_win,
    input logic dma_done,
    input logic host_ack_n,
    input logic host_hold,
    input logic host_timeout,
    input logic ram_en
);
    AST_FREE_HOST_PASS: assert property (@(posedge clk) disable iff (rst)
        !host_hold |-> (ram_en == host_req)); // R1

    AST_ACK_NEEDS_PRIOR_REQ: assert property (@(posedge clk) disable iff (rst)
        $fell(host_ack_n) |-> $past(host_req)); // R2

    AST_ACK_INSIDE_WINDOW: assert property (@(posedge clk) disable iff (rst)
        !host_ack_n |-> $past(strobe_win)); // R2

    AST_TIMEOUT_STICKY: assert property (@(posedge clk) disable iff (rst)
        host_timeout |=> host_timeout); // R4

    AST_TIMEOUT_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
        $rose(host_timeout) |-> $past(host_req)); // R4

    AST_RELEASE_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
        $fell(host_hold) |-> $past(dma_done)); // R6
endmodule

bind ram_share_arbiter ram_share_arbiter_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .host_req     (host_req),
    .strobe_win   (strobe_win),
    .dma_done     (dma_done),
    .host_ack_n   (host_ack_n),
    .host_hold    (host_hold),
    .host_timeout (host_timeout),
    .ram_en       (ram_en)
);

// File: tb/ram_share_arbiter_tb.sv
module ram_share_arbiter_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW  = 8;
    localparam int DW  = 16;
    localparam int ACK = 3;
    localparam int FIN = 5;
    localparam int LIM = ACK + FIN;
    localparam logic [AW-1:0] DMA_ADDR  = 8'h50;
    localparam logic [DW-1:0] DMA_WDATA = 16'hD0D0;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic host_req = 0, host_we = 0, strobe_win = 0, dma_req = 0, dma_done = 0;
    logic dma_we = 1'b1;
    logic [AW-1:0] host_addr = '0;
    logic [DW-1:0] host_wdata = '0;
    logic host_ack_n, host_hold, host_timeout, ram_en, ram_we;
    logic [AW-1:0] ram_addr;
    logic [DW-1:0] ram_wdata;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ram_share_arbiter #(.ADDR_W(AW), .DATA_W(DW), .ACK_CYC(ACK), .FINISH_CYC(FIN)) u_dut (
        .clk(clk), .rst(rst), .host_req(host_req), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata), .strobe_win(strobe_win),
        .dma_req(dma_req), .dma_we(dma_we), .dma_addr(DMA_ADDR), .dma_wdata(DMA_WDATA),
        .dma_done(dma_done), .host_ack_n(host_ack_n), .host_hold(host_hold),
        .host_timeout(host_timeout), .ram_en(ram_en), .ram_we(ram_we),
        .ram_addr(ram_addr), .ram_wdata(ram_wdata)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    // inputs: strb hreq hwe haddr dreq done | expected: en we addr hold ackn
    function automatic logic [24:0] mk(input logic s, input logic r, input logic w,
                                       input logic [7:0] a, input logic dr, input logic dn,
                                       input logic en, input logic we, input logic [7:0] ea,
                                       input logic hd, input logic ak);
        return {s, r, w, a, dr, dn, en, we, ea, hd, ak};
    endfunction

    localparam int NV = 13;
    localparam logic [24:0] VEC [NV] = '{
        mk(0,0,0,8'h00,0,0, 0,0,8'h00,0,1),  // R1 idle
        mk(0,1,1,8'hA1,0,0, 1,1,8'hA1,0,1),  // R1 write
        mk(0,1,0,8'hA2,1,0, 1,0,8'hA2,0,1),  // R5 dma ignored idle
        mk(1,1,0,8'hA3,0,0, 1,0,8'hA3,0,1),  // R2 window start, in progress
        mk(1,1,1,8'hA4,0,0, 1,1,8'hA4,0,0),  // R2 ack, host keeps RAM
        mk(1,1,0,8'hA5,1,0, 1,0,8'hA5,0,0),  // R5 dma ignored in window
        mk(1,0,0,8'h00,0,0, 0,0,8'h00,1,0),  // R2 access done, ack continues
        mk(1,1,1,8'hA7,0,0, 0,0,8'h00,1,1),  // R3 late request held
        mk(0,1,1,8'hA8,1,0, 0,0,8'h00,1,1),  // R3 window closing
        mk(0,1,1,8'hA9,1,0, 1,1,8'h50,1,1),  // R5 DMA owns
        mk(0,1,1,8'hAA,0,1, 0,0,8'h00,1,1),  // R3 done cycle still held
        mk(0,1,1,8'hAB,0,0, 1,1,8'hAB,0,1),  // R6 released and served
        mk(0,0,0,8'h00,0,0, 0,0,8'h00,0,1)   // R1 idle
    };

    task automatic drive(input logic s, input logic r, input logic w, input logic [7:0] a,
                         input logic dr, input logic dn);
        strobe_win = s; host_req = r; host_we = w; host_addr = a;
        host_wdata = 16'h1000 | 16'(a); dma_req = dr; dma_done = dn;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        drive(0,0,0,8'h00,0,0);
        @(negedge clk);
        @(negedge clk);
        #1;
        chk("R7 hold", 32'(host_hold), 0);
        chk("R7 ack_n", 32'(host_ack_n), 1);
        chk("R7 timeout", 32'(host_timeout), 0);
        chk("R7 ram_en", 32'(ram_en), 0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        do_reset();
        // Vector walk
        for (int i = 0; i < NV; i++) begin
            logic [24:0] v;
            v = VEC[i];
            drive(v[24], v[23], v[22], v[21:14], v[13], v[12]);
            #1;
            chk($sformatf("vec%0d R1/R5 ram_en", i), 32'(ram_en), 32'(v[11]));
            chk($sformatf("vec%0d R3 hold", i), 32'(host_hold), 32'(v[1]));
            chk($sformatf("vec%0d R2 ack_n", i), 32'(host_ack_n), 32'(v[0]));
            chk($sformatf("vec%0d R4 timeout", i), 32'(host_timeout), 0);
            if (v[11]) begin
                chk($sformatf("vec%0d R5 ram_we", i), 32'(ram_we), 32'(v[10]));
                chk($sformatf("vec%0d R5 ram_addr", i), 32'(ram_addr), 32'(v[9:2]));
                chk($sformatf("vec%0d R5 ram_wdata", i), 32'(ram_wdata),
                    (v[9:2] == DMA_ADDR && v[13]) ? 32'(DMA_WDATA) : 32'(16'h1000 | 16'(v[21:14])));
            end
            @(negedge clk);
        end

        // R4: deadline abort, ack length, sticky flag
        do_reset();
        drive(1,1,1,8'hC0,0,0);
        #1 chk("R4 start grant", 32'(ram_en), 1);
        for (int k = 0; k < LIM; k++) begin
            @(negedge clk);
            #1;
            chk($sformatf("R4 grant cnt%0d", k), 32'(ram_en), 1);
            chk($sformatf("R2 ack cnt%0d", k), 32'(host_ack_n), (k < ACK) ? 0 : 1);
        end
        @(negedge clk);
        #1;
        chk("R4 abort en", 32'(ram_en), 0);
        chk("R4 abort hold", 32'(host_hold), 1);
        chk("R4 flag not yet", 32'(host_timeout), 0);
        @(negedge clk);
        #1 chk("R4 flag set", 32'(host_timeout), 1);
        drive(0,0,0,8'h00,0,0);
        @(negedge clk);
        drive(0,0,0,8'h00,0,1);
        @(negedge clk);
        drive(0,0,0,8'h00,0,0);
        @(negedge clk);
        #1;
        chk("R4 sticky after idle", 32'(host_timeout), 1);
        chk("R1 hold low after DMA", 32'(host_hold), 0);

        // R4: window closes over a live access
        do_reset();
        drive(1,1,0,8'hC1,0,0);
        @(negedge clk);
        #1 chk("R4 close grant", 32'(ram_en), 1);
        @(negedge clk);
        drive(0,1,0,8'hC1,0,0);
        #1;
        chk("R4 close abort en", 32'(ram_en), 0);
        @(negedge clk);
        #1 chk("R4 close flag", 32'(host_timeout), 1);

        // R3: window with no host activity, no ack anywhere
        do_reset();
        drive(1,0,0,8'h00,0,0);
        @(negedge clk);
        #1;
        chk("R3 no ack cnt0", 32'(host_ack_n), 1);
        drive(1,1,1,8'hC2,0,0);
        #1;
        chk("R3 late req blocked", 32'(ram_en), 0);
        chk("R3 late req hold", 32'(host_hold), 1);
        @(negedge clk);
        #1 chk("R3 no ack cnt1", 32'(host_ack_n), 1);

        // R6: pending request across done, released next cycle
        drive(0,1,1,8'hC3,0,0);
        @(negedge clk);
        drive(0,1,1,8'hC3,1,0);
        #1 chk("R5 dma owns", 32'(ram_addr), 32'(DMA_ADDR));
        @(negedge clk);
        drive(0,1,1,8'hC3,0,1);
        #1 chk("R6 hold in done cycle", 32'(host_hold), 1);
        @(negedge clk);
        drive(0,1,1,8'hC3,0,0);
        #1;
        chk("R6 hold released", 32'(host_hold), 0);
        chk("R6 served addr", 32'(ram_addr), 32'h00C3);
        chk("R6 served en", 32'(ram_en), 1);
        chk("R4 no timeout", 32'(host_timeout), 0);

        summary();
        $finish;
    end
endmodule